// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block turns one DRAM read or write burst request into the ordered list of column addresses that the burst visits. A request carries a starting column. The block then presents one column address per beat on an output stream and flags the final beat. The burst always stays inside an aligned group of columns whose size equals the programmed burst length. Within that group the order is either a wrapping count or the start index XORed with the beat number.

A second port receives mode-register writes. For writes aimed at the main register, the block decodes the burst length, the burst order, the read latency, the test-mode bit and the DLL-reset bit, and it keeps the decoded values. A write that holds a reserved length or latency code is refused. The old settings stay in force and an error flag is raised. Writes aimed at the extended register pass by without effect.

Both streams use valid/ready. A request is taken only when `req_valid` and `req_ready` are both high, and `req_ready` stays low for the whole of a burst. A beat is consumed when `beat_valid` and `beat_ready` are both high. While `beat_ready` is low the current beat is held unchanged, so the consumer may apply back-pressure for any number of cycles.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_valid`=0, `req_ready`=1, burst length 2, sequential order, latency 3, and `mode_err`, `cfg_dll_reset` and `cfg_test_mode` all 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Beat 0, equal to the start column, is valid after that edge. `req_ready` stays 0 until the last beat has been consumed, and requests offered in that time are ignored.
- R3: In sequential order (mode bit 3 = 0), beat i carries low bits (s + i) mod L, where s is the start's low bits and L is the burst length.
- R4: In interleaved order (mode bit 3 = 1), beat i carries low bits s XOR i, taken within the L-column group.
- R5: Column bits at and above log2(L) never change during a burst. Only the low 1, 2 or 3 bits move.
- R6: `beat_last` is 1 only on beat L-1. After that beat is consumed, `beat_valid` is 0 and `req_ready` is 1 on the next cycle.
- R7: While `beat_valid`=1 and `beat_ready`=0, the beat's column and its last flag stay unchanged.
- R8: Mode bits [2:0] set the burst length: 001 gives 2, 010 gives 4, 011 gives 8. `cfg_burst_len` gives the length as a number and `cfg_interleave` gives bit 3. The new value shows one cycle after the write.
- R9: Mode bits [6:4] set the read latency: 011 gives 3, 100 gives 4. `cfg_cas_lat` gives it as a number.
- R10: Mode bit 7 is reported on `cfg_test_mode` and bit 8 on `cfg_dll_reset`.
- R11: A main-register write with any other length code or latency code leaves every `cfg_*` output unchanged and sets `mode_err`. A legal write clears `mode_err`.
- R12: A write with `mode_ext`=1 (extended register) changes no `cfg_*` output and does not change `mode_err`.
- R13: A burst keeps the length and order that were in force when it was accepted, even if the mode is rewritten during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode-register write strobe |
| mode_ext | input | 1 | Register select: 0 main, 1 extended |
| mode_word | input | 13 | Mode-register operand |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Block can take a request |
| req_col | input | 9 | Starting column of the request |
| beat_valid | output | 1 | Beat column valid |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_col | output | 9 | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| cfg_burst_len | output | 4 | Decoded burst length (2, 4 or 8) |
| cfg_interleave | output | 1 | Decoded order: 1 interleaved |
| cfg_cas_lat | output | 3 | Decoded read latency (3 or 4) |
| cfg_dll_reset | output | 1 | DLL-reset request bit |
| cfg_test_mode | output | 1 | Test-mode bit |
| mode_err | output | 1 | Last main-register write held a reserved code |

## Verification
The assertions assume that reset is applied at the start. They also assume that `beat_ready` and `req_valid` are only sampled at clock edges, so a stalled beat is judged only by what it shows at the next edge. The bench drives every input on the falling edge. It sweeps each legal length, both orders and all eight start offsets, with upper column bits that change from burst to burst and a fixed stall pattern on `beat_ready`. It tries every combination of length code and latency code, with a mode rewrite and a competing request injected in the middle of a burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // widest burst is 8 beats, so three low column bits can move
  localparam int IDX_W = 3;

  // mode word field positions
  localparam int F_LEN_LSB = 0;
  localparam int F_ORD_BIT = 3;
  localparam int F_LAT_LSB = 4;
  localparam int F_TST_BIT = 7;
  localparam int F_DLL_BIT = 8;

  typedef enum logic [1:0] {
    LEN_2 = 2'd0,
    LEN_4 = 2'd1,
    LEN_8 = 2'd2
  } blen_e;

  // mask of the column bits that move within a burst
  function automatic logic [IDX_W-1:0] len_mask(input blen_e l);
    case (l)
      LEN_2:   len_mask = 3'b001;
      LEN_4:   len_mask = 3'b011;
      default: len_mask = 3'b111;
    endcase
  endfunction

  function automatic logic [3:0] len_value(input blen_e l);
    case (l)
      LEN_2:   len_value = 4'd2;
      LEN_4:   len_value = 4'd4;
      default: len_value = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ext,
  input  logic [ADDR_W-1:0] wr_word,
  output blen_e             len_code,
  output logic              interleave,
  output logic [2:0]        cas_lat,
  output logic              dll_reset,
  output logic              test_mode,
  output logic              err
);
  logic [2:0] len_f, lat_f;
  logic       len_ok, lat_ok, legal;
  blen_e      len_dec;

  assign len_f = wr_word[F_LEN_LSB +: 3];
  assign lat_f = wr_word[F_LAT_LSB +: 3];

  always_comb begin
    len_ok  = 1'b1;
    len_dec = LEN_2;
    case (len_f)
      3'b001:  len_dec = LEN_2;
      3'b010:  len_dec = LEN_4;
      3'b011:  len_dec = LEN_8;
      default: len_ok  = 1'b0;
    endcase
  end

  assign lat_ok = (lat_f == 3'b011) || (lat_f == 3'b100);
  assign legal  = len_ok && lat_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_code   <= LEN_2;
      interleave <= 1'b0;
      cas_lat    <= 3'd3;
      dll_reset  <= 1'b0;
      test_mode  <= 1'b0;
      err        <= 1'b0;
    end else if (wr_en && !wr_ext) begin
      if (legal) begin
        len_code   <= len_dec;
        interleave <= wr_word[F_ORD_BIT];
        cas_lat    <= lat_f;
        dll_reset  <= wr_word[F_DLL_BIT];
        test_mode  <= wr_word[F_TST_BIT];
        err        <= 1'b0;
      end else begin
        err        <= 1'b1;
      end
    end
  end

  AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 3'd3) || (cas_lat == 3'd4)); // R9

  AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ext && !legal) |=> ($stable(len_code) && $stable(cas_lat) && $stable(interleave) && err)); // R11

  AST_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ext) |=> ($stable(len_code) && $stable(cas_lat) && $stable(interleave) && $stable(err))); // R12
endmodule

// File: rtl/bcs_burst_gen.sv
module bcs_burst_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [COL_W-1:0] req_col,
  input  blen_e            len_code,
  input  logic             interleave,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last
);
  localparam int HI_W = COL_W - IDX_W;

  logic             busy;
  logic [COL_W-1:0] start_q;
  logic [IDX_W-1:0] mask_q;
  logic             il_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] low_seq, low_il, low_sel;
  logic             take_req, take_beat;

  assign req_ready  = !busy;
  assign beat_valid = busy;
  assign take_req   = req_valid && !busy;
  assign take_beat  = busy && beat_ready;

  assign low_seq = start_q[IDX_W-1:0] + idx_q;
  assign low_il  = start_q[IDX_W-1:0] ^ idx_q;
  assign low_sel = il_q ? low_il : low_seq;

  assign beat_col  = {start_q[COL_W-1:IDX_W],
                      (start_q[IDX_W-1:0] & ~mask_q) | (low_sel & mask_q)};
  assign beat_last = busy && (idx_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      start_q <= '0;
      mask_q  <= '0;
      il_q    <= 1'b0;
      idx_q   <= '0;
    end else if (take_req) begin
      busy    <= 1'b1;
      start_q <= req_col;
      mask_q  <= len_mask(len_code);
      il_q    <= interleave;
      idx_q   <= '0;
    end else if (take_beat) begin
      if (beat_last) busy <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_col) && $stable(beat_last))); // R7

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> (!beat_valid && req_ready)); // R6

  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready); // R2

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid) && !$past(beat_last && beat_ready))
      |-> (beat_col[COL_W-1:IDX_W] == $past(beat_col[COL_W-1:IDX_W]))); // R5

  if (HI_W < 1) begin : g_bad_width
    initial $error("column width must exceed the burst index width");
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              mode_ext,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [COL_W-1:0]  req_col,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_last,
  output logic [3:0]        cfg_burst_len,
  output logic              cfg_interleave,
  output logic [2:0]        cfg_cas_lat,
  output logic              cfg_dll_reset,
  output logic              cfg_test_mode,
  output logic              mode_err
);
  blen_e len_code;

  bcs_mode_decode #(.ADDR_W(ADDR_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (mode_we),
    .wr_ext     (mode_ext),
    .wr_word    (mode_word),
    .len_code   (len_code),
    .interleave (cfg_interleave),
    .cas_lat    (cfg_cas_lat),
    .dll_reset  (cfg_dll_reset),
    .test_mode  (cfg_test_mode),
    .err        (mode_err)
  );

  bcs_burst_gen #(.COL_W(COL_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_col    (req_col),
    .len_code   (len_code),
    .interleave (cfg_interleave),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_col   (beat_col),
    .beat_last  (beat_last)
  );

  assign cfg_burst_len = len_value(len_code);
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0, mode_ext = 1'b0;
  logic [12:0] mode_word = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [8:0]  req_col = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [8:0]  beat_col;
  logic        beat_last;
  logic [3:0]  cfg_burst_len;
  logic        cfg_interleave;
  logic [2:0]  cfg_cas_lat;
  logic        cfg_dll_reset, cfg_test_mode, mode_err;

  int checks = 0;
  int failures = 0;

  // bench model of the programmed mode
  int m_len = 2, m_il = 0, m_cl = 3, m_dll = 0, m_tm = 0, m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_ext(mode_ext),
    .mode_word(mode_word), .req_valid(req_valid), .req_ready(req_ready),
    .req_col(req_col), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_col(beat_col), .beat_last(beat_last), .cfg_burst_len(cfg_burst_len),
    .cfg_interleave(cfg_interleave), .cfg_cas_lat(cfg_cas_lat),
    .cfg_dll_reset(cfg_dll_reset), .cfg_test_mode(cfg_test_mode), .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic model_write(input bit ext, input int w);
    int blc, clc;
    if (ext) return;
    blc = w & 7;
    clc = (w >> 4) & 7;
    if (blc >= 1 && blc <= 3 && (clc == 3 || clc == 4)) begin
      m_len = 1 << blc;
      m_il  = (w >> 3) & 1;
      m_cl  = clc;
      m_tm  = (w >> 7) & 1;
      m_dll = (w >> 8) & 1;
      m_err = 0;
    end else begin
      m_err = 1;
    end
  endtask

  task automatic check_cfg(input string tag);
    chk_eq({tag, "/R8"}, "burst_len", int'(cfg_burst_len), m_len);
    chk_eq({tag, "/R8"}, "interleave", int'(cfg_interleave), m_il);
    chk_eq({tag, "/R9"}, "cas_lat", int'(cfg_cas_lat), m_cl);
    chk_eq({tag, "/R10"}, "dll_reset", int'(cfg_dll_reset), m_dll);
    chk_eq({tag, "/R10"}, "test_mode", int'(cfg_test_mode), m_tm);
    chk_eq({tag, "/R11"}, "mode_err", int'(mode_err), m_err);
  endtask

  task automatic write_mode(input bit ext, input int w, input string tag);
    @(negedge clk);
    mode_we = 1'b1; mode_ext = ext; mode_word = 13'(w);
    @(negedge clk);
    mode_we = 1'b0; mode_ext = 1'b0;
    model_write(ext, w);
    check_cfg(tag);
  endtask

  // runs one burst; mid=1 injects a mode rewrite and a competing request at beat 0
  task automatic run_burst(input int col, input int len, input int il, input bit mid);
    int s, e, ofs;
    bit stall;
    @(negedge clk);
    chk_eq("R2", "req_ready idle", int'(req_ready), 1);
    req_col = 9'(col); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    s = col & (len - 1);
    for (int i = 0; i < len; i++) begin
      if (il != 0) ofs = s ^ i; else ofs = (s + i) % len;
      e = (col & ~(len - 1)) | ofs;
      chk_eq("R2", "beat_valid", int'(beat_valid), 1);
      chk_eq("R2", "req_ready busy", int'(req_ready), 0);
      chk_eq(il != 0 ? "R4" : "R3", "beat_col", int'(beat_col), e);
      chk_eq("R5", "upper bits", int'(beat_col) & ~(len - 1), col & ~(len - 1));
      chk_eq("R6", "beat_last", int'(beat_last), (i == len - 1) ? 1 : 0);
      if (mid && i == 0) begin
        mode_we = 1'b1; mode_word = 13'h03B; // length 8, interleaved, latency 3
        req_valid = 1'b1; req_col = 9'(col ^ 9'h1FF);
      end
      stall = ((i + col + len) % 3) == 0;
      if (stall) begin
        beat_ready = 1'b0;
        @(negedge clk);
        mode_we = 1'b0; req_valid = 1'b0;
        chk_eq("R7", "held col", int'(beat_col), e);
        chk_eq("R7", "held last", int'(beat_last), (i == len - 1) ? 1 : 0);
        chk_eq("R7", "held valid", int'(beat_valid), 1);
      end
      beat_ready = 1'b1;
      @(negedge clk);
      beat_ready = 1'b0; mode_we = 1'b0; req_valid = 1'b0;
    end
    chk_eq("R6", "valid after last", int'(beat_valid), 0);
    chk_eq("R6", "ready after last", int'(req_ready), 1);
    if (mid) begin
      model_write(1'b0, 13'h03B);
      check_cfg("R13");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1", "beat_valid", int'(beat_valid), 0);
    chk_eq("R1", "req_ready", int'(req_ready), 1);
    check_cfg("R1");

    // R3 R4 R5 R6 R7 sweep over lengths, orders, start offsets
    for (int lc = 1; lc <= 3; lc++) begin
      for (int bt = 0; bt < 2; bt++) begin
        write_mode(1'b0, ((3 + (lc & 1)) << 4) | (bt << 3) | lc, "R8");
        for (int s = 0; s < 8; s++) begin
          run_burst((((s * 53 + lc * 7 + bt) & 63) << 3) | s, 1 << lc, bt, 1'b0);
        end
      end
    end

    // R11: every length/latency code combination, with R10 bits toggled
    for (int blc = 0; blc < 8; blc++) begin
      for (int clc = 0; clc < 8; clc++) begin
        write_mode(1'b0, (((blc ^ clc) & 1) << 8) | (((blc + clc) & 1) << 7)
                         | (clc << 4) | ((blc & 1) << 3) | blc, "R11");
      end
    end

    // R12: extended writes after an error and after a legal write
    write_mode(1'b0, 13'h000, "R11");
    write_mode(1'b1, 13'h032, "R12");
    write_mode(1'b0, 13'h142, "R10");
    write_mode(1'b1, 13'h0BB, "R12");
    run_burst(9'h0A7, 4, 0, 1'b0);

    // R13: rewrite during a burst; R2: request during a burst ignored
    write_mode(1'b0, 13'h032, "R8");
    run_burst(9'h16D, 4, 0, 1'b1);
    run_burst(9'h16D, 8, 1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule